// File: doc/BRIEF.md
# Half-Bridge Gate Protection and Status Latch

This block sits between the command register of a three-channel half-bridge driver and its power stage. For each channel it receives a commanded high-side and low-side enable and turns them into the gate enables actually applied, after shoot-through, supply, overcurrent and thermal protection. It also keeps the sticky status flags that a serial readback reports, and clears them when a status-reset strobe arrives.

A supervisor state machine has three states. `MD_SLEEP` is entered on reset or whenever enable is low. `MD_ACTIVE` is the normal running state. `MD_TSD_LOCK` is held after a thermal shutdown. Its transitions are:
- wake: `MD_SLEEP` to `MD_ACTIVE` on the first clock with enable high;
- trip: `MD_ACTIVE` to `MD_TSD_LOCK` when any thermal-shutdown flag is sampled;
- release: `MD_TSD_LOCK` to `MD_ACTIVE` on the strobe when no shutdown flag is present;
- sleep: any state to `MD_SLEEP` when enable is low.

Each channel also has an overcurrent timer with three states. `OC_IDLE` moves to `OC_TIMING` (start) when overcurrent is first seen, and the delay is captured at that point. `OC_TIMING` returns to `OC_IDLE` (abort) when the flag drops, and moves to `OC_TRIPPED` (expire) when the delay runs out. `OC_TRIPPED` returns to `OC_IDLE` (rearm) on the strobe. Every timer falls to `OC_IDLE` when enable is low.

Top module: `hb_gate_protect`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, all six gate enables and all four status flags are 0.
- R2: In `MD_ACTIVE` with no fault present, bit c of `gate_hs_o` equals bit c of `cmd_hs_i`, and bit c of `gate_ls_o` equals bit c of `cmd_ls_i`, independently for each channel c in 0..2.
- R3: A channel commanded with both its high side and its low side on has both gates off in that same cycle, and `sta_o` reads 1 from the next cycle. The channel stays off until a `srr_i` strobe clears the flag. A strobe in a cycle where both sides are still commanded on leaves the flag set.
- R4: `ov_i` or `uv_i` sets `psf_o` from the next cycle. `psf_o` clears only on a `srr_i` strobe made while neither condition is present.
- R5: While `uv_i` is 1, all gates are 0 in the same cycle.
- R6: While `ov_i` is 1 and `ovlo_en_i` is 1, all gates are 0. When `ov_i` drops, the commanded gates return with no strobe. With `ovlo_en_i` at 0, `ov_i` does not affect the gates.
- R7: `oc_i[c]` high for N consecutive sampled cycles latches channel c off and sets `ocd_o` after the Nth edge. N is `OC_SLOW_CYC` (default 40) when `oc_fast_i` is 0 at the first of those cycles, and `OC_FAST_CYC` (default 6) when it is 1. A drop of `oc_i[c]` before the Nth cycle restarts the count.
- R8: Changing `oc_fast_i` after a channel's overcurrent count has started does not change that count's delay.
- R9: A channel latched off by overcurrent stays off until a `srr_i` strobe. From the cycle after the strobe it follows its command again, and `ocd_o` reads 0 if no other channel is latched.
- R10: Any `tw_i` bit sets `tw_flag_o` from the next cycle, and the gates are not affected. A strobe clears the flag only when all `tw_i` bits are 0.
- R11: Any `tsd_i` bit turns all gates off from the next cycle. They stay off after the flag drops, until a strobe arrives while no `tsd_i` bit is set.
- R12: `en_i` at 0 forces all gates to 0 in the same cycle and clears every flag and latch at the next edge. After `en_i` rises, gates follow their commands from the second cycle onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_i | input | 1 | Device enable; low means sleep |
| cmd_hs_i | input | NCH | Commanded high-side enables, bit c = channel c |
| cmd_ls_i | input | NCH | Commanded low-side enables, bit c = channel c |
| ovlo_en_i | input | 1 | Overvoltage lockout enable |
| oc_fast_i | input | 1 | Overcurrent delay select: 1 = short, 0 = long |
| srr_i | input | 1 | Status-reset strobe, one cycle |
| ov_i | input | 1 | Supply overvoltage comparator |
| uv_i | input | 1 | Supply undervoltage comparator |
| oc_i | input | NCH | Per-channel overcurrent comparator |
| tw_i | input | NCH | Per-channel thermal warning comparator |
| tsd_i | input | NCH | Per-channel thermal shutdown comparator |
| gate_hs_o | output | NCH | Applied high-side gate enables |
| gate_ls_o | output | NCH | Applied low-side gate enables |
| psf_o | output | 1 | Sticky supply fault flag |
| tw_flag_o | output | 1 | Sticky thermal warning flag |
| sta_o | output | 1 | Sticky shoot-through attempt flag |
| ocd_o | output | 1 | Overcurrent latch-off flag |

## Verification
The status-reset strobe can fall in the same cycle as an active fault condition: a shoot-through command, a supply fault, a thermal warning or an overcurrent trip. The set must then win, and the flag must stay up. The bench provokes this by pulsing the strobe while a condition is still held, and then again after the condition has dropped. A cycle-accurate behavioural model, compared on every clock, judges both the flag and the gate outcome. The change of delay select during a running overcurrent count is a second coincidence. It is provoked in both directions, and the bench checks that the trip lands exactly at the delay captured at the start.

// File: rtl/hb_pkg.sv
package hb_pkg;

    typedef enum logic [1:0] {
        OC_IDLE    = 2'd0,
        OC_TIMING  = 2'd1,
        OC_TRIPPED = 2'd2
    } oc_state_e;

    typedef enum logic [1:0] {
        MD_SLEEP    = 2'd0,
        MD_ACTIVE   = 2'd1,
        MD_TSD_LOCK = 2'd2
    } mode_e;

endpackage

// File: rtl/hb_oc_timer.sv
module hb_oc_timer
    import hb_pkg::*;
#(
    parameter int OC_SLOW_CYC = 40,
    parameter int OC_FAST_CYC = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic oc_i,
    input  logic fast_i,
    input  logic srr_i,
    output logic trip_o
);
    localparam int CW = $clog2(OC_SLOW_CYC + 1);
    localparam logic [CW-1:0] LIM_SLOW = CW'(OC_SLOW_CYC);
    localparam logic [CW-1:0] LIM_FAST = CW'(OC_FAST_CYC);

    oc_state_e st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [CW-1:0] lim_q, lim_d;

    // next-state process
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        lim_d = lim_q;
        unique case (st_q)
            OC_IDLE: begin
                if (oc_i) begin                      // start
                    st_d  = OC_TIMING;
                    cnt_d = CW'(1);
                    lim_d = fast_i ? LIM_FAST : LIM_SLOW;
                end
            end
            OC_TIMING: begin
                if (!oc_i) begin                     // abort
                    st_d  = OC_IDLE;
                    cnt_d = '0;
                end else if (cnt_q == lim_q - CW'(1)) begin  // expire
                    st_d  = OC_TRIPPED;
                    cnt_d = '0;
                end else begin
                    cnt_d = cnt_q + CW'(1);
                end
            end
            OC_TRIPPED: begin
                if (srr_i) st_d = OC_IDLE;           // rearm
            end
            default: st_d = OC_IDLE;
        endcase
        if (!en_i) begin
            st_d  = OC_IDLE;
            cnt_d = '0;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= OC_IDLE;
            cnt_q <= '0;
            lim_q <= LIM_SLOW;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            lim_q <= lim_d;
        end
    end

    // outputs
    assign trip_o = (st_q == OC_TRIPPED);

    p_lim_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == OC_TIMING && en_i && oc_i) |=> $stable(lim_q));

    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == OC_TIMING) |-> (cnt_q < lim_q));

    p_trip_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == OC_TRIPPED && en_i && !srr_i) |=> (st_q == OC_TRIPPED));

endmodule

// File: rtl/hb_supervisor.sv
module hb_supervisor
    import hb_pkg::*;
#(
    parameter int NCH = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en_i,
    input  logic           srr_i,
    input  logic           ov_i,
    input  logic           uv_i,
    input  logic           tw_any_i,
    input  logic           tsd_any_i,
    input  logic [NCH-1:0] both_on_i,
    output logic           active_o,
    output logic           psf_o,
    output logic           tw_o,
    output logic [NCH-1:0] sta_ch_o
);
    mode_e md_q, md_d;
    logic psf_q, psf_d, tw_q, tw_d;
    logic [NCH-1:0] sta_q, sta_d;

    // next-state process
    always_comb begin
        md_d = md_q;
        unique case (md_q)
            MD_SLEEP:    md_d = MD_ACTIVE;                            // wake
            MD_ACTIVE:   if (tsd_any_i) md_d = MD_TSD_LOCK;           // trip
            MD_TSD_LOCK: if (srr_i && !tsd_any_i) md_d = MD_ACTIVE;   // release
            default:     md_d = MD_SLEEP;
        endcase
        psf_d = (ov_i | uv_i) | (psf_q & ~srr_i);
        tw_d  = tw_any_i | (tw_q & ~srr_i);
        sta_d = both_on_i | (sta_q & ~{NCH{srr_i}});
        if (!en_i) begin                                              // sleep
            md_d  = MD_SLEEP;
            psf_d = 1'b0;
            tw_d  = 1'b0;
            sta_d = '0;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            md_q  <= MD_SLEEP;
            psf_q <= 1'b0;
            tw_q  <= 1'b0;
            sta_q <= '0;
        end else begin
            md_q  <= md_d;
            psf_q <= psf_d;
            tw_q  <= tw_d;
            sta_q <= sta_d;
        end
    end

    // outputs
    assign active_o = en_i && (md_q == MD_ACTIVE);
    assign psf_o    = psf_q;
    assign tw_o     = tw_q;
    assign sta_ch_o = sta_q;

    p_sta_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && |both_on_i) |=> (|sta_ch_o));

    p_psf_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && (ov_i || uv_i)) |=> psf_o);

    p_tw_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && tw_any_i) |=> tw_o);

    p_lock_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && md_q == MD_TSD_LOCK && !srr_i) |=> (md_q == MD_TSD_LOCK));

endmodule

// File: rtl/hb_gate_protect.sv
module hb_gate_protect
    import hb_pkg::*;
#(
    parameter int NCH         = 3,
    parameter int OC_SLOW_CYC = 40,
    parameter int OC_FAST_CYC = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en_i,
    input  logic [NCH-1:0] cmd_hs_i,
    input  logic [NCH-1:0] cmd_ls_i,
    input  logic           ovlo_en_i,
    input  logic           oc_fast_i,
    input  logic           srr_i,
    input  logic           ov_i,
    input  logic           uv_i,
    input  logic [NCH-1:0] oc_i,
    input  logic [NCH-1:0] tw_i,
    input  logic [NCH-1:0] tsd_i,
    output logic [NCH-1:0] gate_hs_o,
    output logic [NCH-1:0] gate_ls_o,
    output logic           psf_o,
    output logic           tw_flag_o,
    output logic           sta_o,
    output logic           ocd_o
);
    logic [NCH-1:0] both_on, trip, sta_ch, ch_ok;
    logic           active, supply_ok;

    assign both_on = cmd_hs_i & cmd_ls_i;

    hb_supervisor #(.NCH(NCH)) u_sup (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (en_i),
        .srr_i     (srr_i),
        .ov_i      (ov_i),
        .uv_i      (uv_i),
        .tw_any_i  (|tw_i),
        .tsd_any_i (|tsd_i),
        .both_on_i (both_on),
        .active_o  (active),
        .psf_o     (psf_o),
        .tw_o      (tw_flag_o),
        .sta_ch_o  (sta_ch)
    );

    assign supply_ok = !uv_i && !(ov_i && ovlo_en_i);

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        hb_oc_timer #(
            .OC_SLOW_CYC (OC_SLOW_CYC),
            .OC_FAST_CYC (OC_FAST_CYC)
        ) u_oc (
            .clk    (clk),
            .rst_n  (rst_n),
            .en_i   (en_i),
            .oc_i   (oc_i[c]),
            .fast_i (oc_fast_i),
            .srr_i  (srr_i),
            .trip_o (trip[c])
        );
        assign ch_ok[c]     = active && supply_ok && !sta_ch[c] && !trip[c] && !both_on[c];
        assign gate_hs_o[c] = ch_ok[c] && cmd_hs_i[c];
        assign gate_ls_o[c] = ch_ok[c] && cmd_ls_i[c];
    end

    assign sta_o = |sta_ch;
    assign ocd_o = |trip;

    p_uv_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        uv_i |-> (gate_hs_o == '0 && gate_ls_o == '0));

    p_ovlo_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ov_i && ovlo_en_i) |-> (gate_hs_o == '0 && gate_ls_o == '0));

    p_sleep_off_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |-> (gate_hs_o == '0 && gate_ls_o == '0));

    p_no_cross_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_hs_o & gate_ls_o) == '0);

endmodule

// File: tb/hb_gate_protect_tb_top.sv
module hb_gate_protect_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NCH  = 3;
    localparam int SLOW = 40;
    localparam int FAST = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0, ovlo = 1'b0, fast = 1'b0, srr = 1'b0, ov = 1'b0, uv = 1'b0;
    logic [NCH-1:0] hs = '0, ls = '0, oc = '0, tw = '0, tsd = '0;
    logic [NCH-1:0] g_hs, g_ls;
    logic psf, twf, sta, ocd;

    int errors = 0;
    int checks = 0;
    string tag = "R1";

    // reference model state
    int m_mode = 0;
    bit m_psf = 0, m_tw = 0;
    bit m_sta [NCH];
    bit m_trip[NCH];
    int m_run [NCH];
    int m_lim [NCH];

    always #(CLK_PERIOD/2) clk = ~clk;

    hb_gate_protect #(.NCH(NCH), .OC_SLOW_CYC(SLOW), .OC_FAST_CYC(FAST)) dut_i (
        .clk(clk), .rst_n(rst_n), .en_i(en), .cmd_hs_i(hs), .cmd_ls_i(ls),
        .ovlo_en_i(ovlo), .oc_fast_i(fast), .srr_i(srr), .ov_i(ov), .uv_i(uv),
        .oc_i(oc), .tw_i(tw), .tsd_i(tsd),
        .gate_hs_o(g_hs), .gate_ls_o(g_ls), .psf_o(psf), .tw_flag_o(twf),
        .sta_o(sta), .ocd_o(ocd)
    );

    task automatic compare();
        logic [NCH-1:0] e_hs, e_ls;
        logic [3:0] e_st, a_st;
        bit any_sta = 0, any_trip = 0;
        for (int c = 0; c < NCH; c++) begin
            bit ok;
            ok = rst_n && en && (m_mode == 1) && !m_sta[c] && !m_trip[c] && !uv
                 && !(ov && ovlo) && !(hs[c] && ls[c]);
            e_hs[c] = ok && hs[c];
            e_ls[c] = ok && ls[c];
            any_sta  |= m_sta[c];
            any_trip |= m_trip[c];
        end
        e_st = {m_psf, m_tw, any_sta, any_trip};
        a_st = {psf, twf, sta, ocd};
        checks++;
        if ({g_hs, g_ls} !== {e_hs, e_ls}) begin
            errors++;
            $display("FAIL %s gates: actual hs=%b ls=%b expected hs=%b ls=%b at %0t",
                     tag, g_hs, g_ls, e_hs, e_ls, $time);
        end
        checks++;
        if (a_st !== e_st) begin
            errors++;
            $display("FAIL %s status {psf,tw,sta,ocd}: actual %b expected %b at %0t",
                     tag, a_st, e_st, $time);
        end
    endtask

    task automatic model_update();
        bit any_tsd, any_tw;
        any_tsd = |tsd;
        any_tw  = |tw;
        if (!rst_n || !en) begin
            m_mode = 0; m_psf = 0; m_tw = 0;
            for (int c = 0; c < NCH; c++) begin
                m_sta[c] = 0; m_trip[c] = 0; m_run[c] = 0;
            end
            return;
        end
        case (m_mode)
            0: m_mode = 1;
            1: if (any_tsd) m_mode = 2;
            default: if (srr && !any_tsd) m_mode = 1;
        endcase
        m_psf = ov || uv || (m_psf && !srr);
        m_tw  = any_tw || (m_tw && !srr);
        for (int c = 0; c < NCH; c++) begin
            m_sta[c] = (hs[c] && ls[c]) || (m_sta[c] && !srr);
            if (m_trip[c]) begin
                if (srr) begin m_trip[c] = 0; m_run[c] = 0; end
            end else if (oc[c]) begin
                if (m_run[c] == 0) begin
                    m_lim[c] = fast ? FAST : SLOW;
                    m_run[c] = 1;
                end else if (m_run[c] == m_lim[c] - 1) begin
                    m_trip[c] = 1;
                    m_run[c]  = 0;
                end else begin
                    m_run[c]++;
                end
            end else begin
                m_run[c] = 0;
            end
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            compare();
            @(posedge clk);
            model_update();
            #1;
        end
    endtask

    initial begin
        for (int c = 0; c < NCH; c++) begin
            m_sta[c] = 0; m_trip[c] = 0; m_run[c] = 0; m_lim[c] = SLOW;
        end
        tag = "R1"; hs = 3'b111; ls = 3'b000; en = 1;
        cycles(3);
        rst_n = 1;
        tag = "R12"; cycles(1);                  // wake cycle, gates still off
        tag = "R2";  hs = 3'b101; ls = 3'b010; cycles(3);
        hs = 3'b010; ls = 3'b101; cycles(2);
        hs = 3'b000; ls = 3'b000; cycles(1);
        // shoot-through
        tag = "R3"; hs = 3'b010; ls = 3'b011; cycles(2);
        ls = 3'b001; cycles(2);
        srr = 1; cycles(1); srr = 0; cycles(2);
        ls = 3'b011; cycles(1);
        srr = 1; cycles(1); srr = 0; ls = 3'b001; cycles(2);   // set beats clear
        srr = 1; cycles(1); srr = 0; cycles(2);
        // undervoltage and supply flag
        tag = "R5"; uv = 1; cycles(2); uv = 0;
        tag = "R4"; cycles(2);
        uv = 1; srr = 1; cycles(1); uv = 0; srr = 0; cycles(1);
        srr = 1; cycles(1); srr = 0; cycles(1);
        // overvoltage lockout
        tag = "R6"; ovlo = 1; ov = 1; cycles(3); ov = 0; cycles(2);
        ovlo = 0; ov = 1; cycles(2); ov = 0;
        srr = 1; cycles(1); srr = 0; cycles(1);
        // overcurrent slow delay, aborted then full
        tag = "R7"; hs = 3'b101; ls = 3'b010; fast = 0;
        oc[0] = 1; cycles(20); oc[0] = 0; cycles(2);
        oc[0] = 1; cycles(45); oc[0] = 0; cycles(3);
        tag = "R9"; cycles(2); srr = 1; cycles(1); srr = 0; cycles(2);
        // delay select changed mid-run
        tag = "R8"; fast = 0; oc[2] = 1; cycles(3); fast = 1; cycles(10);
        cycles(30); oc[2] = 0; cycles(1);
        fast = 1; oc[1] = 1; hs = 3'b010; ls = 3'b000; cycles(2);
        fast = 0; cycles(8); oc[1] = 0; cycles(1);
        tag = "R9"; srr = 1; cycles(1); srr = 0; cycles(2);
        // thermal warning
        tag = "R10"; hs = 3'b111; ls = 3'b000; tw[1] = 1; cycles(2);
        srr = 1; cycles(1); srr = 0; tw[1] = 0; cycles(2);
        srr = 1; cycles(1); srr = 0; cycles(1);
        // thermal shutdown
        tag = "R11"; tsd[2] = 1; cycles(2); srr = 1; cycles(1); srr = 0;
        tsd[2] = 0; cycles(2); srr = 1; cycles(1); srr = 0; cycles(2);
        // sleep clears latches
        tag = "R12"; en = 0; cycles(2); en = 1; cycles(3);
        fast = 1; oc[0] = 1; uv = 1; hs = 3'b001; ls = 3'b001; cycles(8);
        oc[0] = 0; uv = 0; en = 0; cycles(1); en = 1; hs = 3'b001; ls = 3'b100; cycles(3);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule